// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This block sits between a big-endian processor port and a window of peripheral registers that are not all the same width. The processor may read or write 1, 2 or 4 bytes at a time. The register window is divided into 4-byte groups, and each group has a native width of one byte, two bytes, four bytes, or "not implemented". The adapter looks up the native width of the addressed group and turns each processor request into a short sequence of native accesses. When the request is wider than the register, it becomes several native accesses in ascending address order. When the request is narrower than the register, it becomes one wider native access, and a write becomes a read-modify-write pair.

The processor side is a simple request/response handshake. A request is accepted while `req_ready` is high. The adapter then issues one native access per clock on the `nat_*` observation outputs. Finally it returns a one-cycle `rsp_valid` carrying the read data. A small byte-array register model is built in and stands in for the real registers.

Top module: `mwa_adapter`

## Requirements
- R1: Only the low 10 bits of `req_addr` form the register offset. Addresses that differ only above bit 9 reach the same register.
- R2: An offset of 0x200 or more makes no native access. It returns 0 for a read, changes nothing for a write, and raises `rsp_valid` in the cycle after acceptance.
- R3: `req_size` is coded 0 = byte, 1 = halfword, and 2 or 3 = word. The offset bits below the access size are cleared. Write data is taken from the low bytes of `req_wdata`. Read data is returned right-justified in `rsp_rdata`, and the lowest address holds the most significant byte.
- R4: Offset bits 7:6 select the native width of a group: 0 = byte, 1 = halfword, 2 = word, 3 = unimplemented. Unimplemented bytes read as 0 and ignore writes, and they are accessed as bytes. After reset, implemented byte i holds (i mod 256) XOR 0x5A.
- R5: When the access size equals the native width, exactly one native access is made at the aligned offset.
- R6: A read narrower than its register makes one native read of the aligned register. It returns the addressed lane: for a byte of a halfword, the upper byte at an even offset; for a halfword of a word, the upper half when offset bits 1:0 are 0.
- R7: A read wider than its registers makes native reads at ascending addresses. The first read fills the most significant part of the result.
- R8: A write narrower than its register makes a native read and then a native write, both at the aligned register address. Only the addressed lane changes value.
- R9: A write wider than its registers makes native writes at ascending addresses. The most significant part of the data goes to the lowest address.
- R10: After reset `req_ready` is high. It stays low from acceptance until after `rsp_valid`. `rsp_valid` lasts one cycle and comes one cycle after the last native access. `req_ready` returns in the following cycle.
- R11: A write response carries `rsp_rdata` = 0.
- R12: Every native access is aligned to its own size, lies below offset 0x200, and has a size equal to the native width of its group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_addr | input | ADDR_W | Processor address |
| req_wdata | input | 32 | Write data, right-justified |
| req_ready | output | 1 | Adapter idle, request accepted |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Read result, right-justified |
| nat_en | output | 1 | Native access this cycle |
| nat_we | output | 1 | Native access is a write |
| nat_size | output | 2 | Native access size, log2 bytes |
| nat_addr | output | OFS_W | Native access offset |
| nat_wdata | output | 32 | Native write data, right-justified |

## Verification
A wrong planned width or access count shows up at once in the number of `nat_en` cycles. It also moves `rsp_valid` earlier or later by whole cycles, so the handshake timing check fails for that same request. A wrong lane shift or merge mask corrupts either the returned data or the value written back. The bench keeps a byte-level model and rereads the whole window after every write sweep, so a write that hits the wrong lane is caught by the next sweep. A wrong alias or range decode shows up either as native activity above 0x1FF or as changed contents in the low window.

// File: rtl/mwa_pkg.sv
package mwa_pkg;

   typedef enum logic [1:0] {
      WID_NONE = 2'd0,
      WID_BYTE = 2'd1,
      WID_HALF = 2'd2,
      WID_WORD = 2'd3
   } wid_e;

   typedef enum logic [1:0] {
      PLAN_VOID   = 2'd0,
      PLAN_DIRECT = 2'd1,
      PLAN_NARROW = 2'd2,
      PLAN_SPLIT  = 2'd3
   } plan_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_RESP = 2'd2
   } st_e;

   // log2 of the native byte count; unimplemented groups are handled as bytes
   function automatic logic [1:0] wid_lg(input wid_e w);
      case (w)
         WID_WORD: return 2'd2;
         WID_HALF: return 2'd1;
         default:  return 2'd0;
      endcase
   endfunction

   // right-justified byte-lane mask for a size given as log2 bytes
   function automatic logic [31:0] lg_mask(input logic [1:0] lg);
      case (lg)
         2'd0:    return 32'h0000_00FF;
         2'd1:    return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/mwa_width_lut.sv
module mwa_width_lut
   import mwa_pkg::*;
#(
   parameter int         OFS_W     = 10,
   parameter int         REGION_LG = 4,
   parameter logic [7:0] WIDTH_MAP = 8'b00_11_10_01
) (
   input  logic [OFS_W-1:0] ofs,
   output wid_e             wid
);

   localparam int SHIFT = REGION_LG + 2;

   logic unused_ofs;
   assign unused_ofs = ^ofs;

   generate
      if (SHIFT >= OFS_W) begin : g_single
         // whole window falls in one region
         assign wid = wid_e'(WIDTH_MAP[1:0]);
      end else begin : g_regions
         logic [1:0] region;
         assign region = 2'(ofs >> SHIFT);
         always_comb begin
            wid = wid_e'(WIDTH_MAP[{region, 1'b0} +: 2]);
         end
      end
   endgenerate

endmodule

// File: rtl/mwa_planner.sv
module mwa_planner
   import mwa_pkg::*;
#(
   parameter int OFS_W = 10,
   parameter int LIMIT = 512
) (
   input  logic             wr,
   input  logic [1:0]       size_code,
   input  logic [OFS_W-1:0] ofs,
   input  wid_e             wid,
   output plan_e            mode,
   output logic [1:0]       sl,
   output logic [1:0]       nl,
   output logic [2:0]       nops,
   output logic [OFS_W-1:0] ofs_al
);

   localparam logic [OFS_W:0] LIMIT_V = (OFS_W+1)'(LIMIT);

   always_comb begin
      case (size_code)
         2'd0:    sl = 2'd0;
         2'd1:    sl = 2'd1;
         default: sl = 2'd2;
      endcase
      nl     = wid_lg(wid);
      ofs_al = ofs & ~(OFS_W'((3'd1 << sl) - 3'd1));
      if ({1'b0, ofs} >= LIMIT_V) begin
         mode = PLAN_VOID;
         nops = 3'd0;
      end else if (sl == nl) begin
         mode = PLAN_DIRECT;
         nops = 3'd1;
      end else if (sl < nl) begin
         mode = PLAN_NARROW;
         nops = wr ? 3'd2 : 3'd1;
      end else begin
         mode = PLAN_SPLIT;
         nops = 3'd1 << (sl - nl);
      end
   end

endmodule

// File: rtl/mwa_subop.sv
module mwa_subop
   import mwa_pkg::*;
#(
   parameter int OFS_W = 10
) (
   input  plan_e            mode,
   input  logic [1:0]       nl,
   input  logic [1:0]       sl,
   input  logic [OFS_W-1:0] ofs,
   input  logic [1:0]       step,
   input  logic [2:0]       nops,
   input  logic             wr,
   input  logic [31:0]      wdata,
   input  logic [31:0]      hold,
   output logic [OFS_W-1:0] op_addr,
   output logic [1:0]       op_size,
   output logic             op_we,
   output logic [31:0]      op_wdata,
   output logic [4:0]       lane_sh
);

   logic [2:0]  nbytes, sbytes, lane_bytes;
   logic [1:0]  lanepos, rem;
   logic [4:0]  piece_sh;
   logic [31:0] nmask, smask;

   always_comb begin
      nbytes     = 3'd1 << nl;
      sbytes     = 3'd1 << sl;
      lanepos    = ofs[1:0] & 2'(nbytes - 3'd1);
      lane_bytes = nbytes - sbytes - {1'b0, lanepos};
      lane_sh    = {lane_bytes[1:0], 3'b000};
      rem        = 2'(nops - 3'd1 - {1'b0, step});
      piece_sh   = (nl == 2'd0) ? {rem, 3'b000} : {rem[0], 4'b0000};
      nmask      = lg_mask(nl);
      smask      = lg_mask(sl);
      op_size    = nl;
      op_addr    = ofs;
      op_we      = 1'b0;
      op_wdata   = 32'd0;
      case (mode)
         PLAN_DIRECT: begin
            op_we    = wr;
            op_wdata = wdata & nmask;
         end
         PLAN_NARROW: begin
            op_addr  = ofs & ~(OFS_W'(nbytes - 3'd1));
            op_we    = wr && (step == 2'd1);
            op_wdata = (hold & ~(smask << lane_sh)) | ((wdata & smask) << lane_sh);
         end
         PLAN_SPLIT: begin
            op_addr  = ofs + (OFS_W'(step) << nl);
            op_we    = wr;
            op_wdata = (wdata >> piece_sh) & nmask;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/mwa_regfile.sv
module mwa_regfile
   import mwa_pkg::*;
#(
   parameter int         OFS_W     = 10,
   parameter int         LIMIT     = 512,
   parameter int         REGION_LG = 4,
   parameter logic [7:0] WIDTH_MAP = 8'b00_11_10_01
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             we,
   input  logic [1:0]       size,
   input  logic [OFS_W-1:0] addr,
   input  logic [31:0]      wdata,
   output logic [31:0]      rdata
);

   localparam int             IDX_W   = $clog2(LIMIT);
   localparam logic [OFS_W:0] LIMIT_V = (OFS_W+1)'(LIMIT);

   logic [7:0]       mem [LIMIT];
   wid_e             wid;
   logic             none;
   logic [IDX_W-1:0] a0, a1, a2, a3;
   logic             unused_addr;

   assign unused_addr = ^addr;

   mwa_width_lut #(.OFS_W(OFS_W), .REGION_LG(REGION_LG), .WIDTH_MAP(WIDTH_MAP)) lut_i (
      .ofs (addr),
      .wid (wid)
   );

   assign none = (wid == WID_NONE);
   assign a0   = IDX_W'(addr);
   assign a1   = IDX_W'(addr + OFS_W'(1));
   assign a2   = IDX_W'(addr + OFS_W'(2));
   assign a3   = IDX_W'(addr + OFS_W'(3));

   always_comb begin
      if (none) begin
         rdata = 32'd0;
      end else begin
         case (size)
            2'd0:    rdata = {24'd0, mem[a0]};
            2'd1:    rdata = {16'd0, mem[a0], mem[a1]};
            default: rdata = {mem[a0], mem[a1], mem[a2], mem[a3]};
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LIMIT; i++) begin
            mem[i] <= 8'(i) ^ 8'h5A;
         end
      end else if (en && we && !none) begin
         case (size)
            2'd0: mem[a0] <= wdata[7:0];
            2'd1: begin
               mem[a0] <= wdata[15:8];
               mem[a1] <= wdata[7:0];
            end
            default: begin
               mem[a0] <= wdata[31:24];
               mem[a1] <= wdata[23:16];
               mem[a2] <= wdata[15:8];
               mem[a3] <= wdata[7:0];
            end
         endcase
      end
   end

   // R12
   nat_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> ((size == 2'd0) || (size == 2'd1 && !addr[0]) || (size == 2'd2 && addr[1:0] == 2'd0)));

   // R12
   nat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> ({1'b0, addr} < LIMIT_V));

   // R12
   nat_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (size == wid_lg(wid)));

   // R4
   nat_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && none) |-> (size == 2'd0));

endmodule

// File: rtl/mwa_adapter.sv
module mwa_adapter
   import mwa_pkg::*;
#(
   parameter int         ADDR_W    = 16,
   parameter int         OFS_W     = 10,
   parameter int         LIMIT     = 512,
   parameter int         REGION_LG = 4,
   parameter logic [7:0] WIDTH_MAP = 8'b00_11_10_01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              nat_en,
   output logic              nat_we,
   output logic [1:0]        nat_size,
   output logic [OFS_W-1:0]  nat_addr,
   output logic [31:0]       nat_wdata
);

   localparam logic [OFS_W:0] LIMIT_V = (OFS_W+1)'(LIMIT);

   generate
      if (LIMIT % 4 != 0 || LIMIT > (1 << OFS_W) || LIMIT < 4) begin : g_bad_limit
         $error("mwa_adapter: LIMIT must be a multiple of 4 inside the offset window");
      end
      if (ADDR_W < OFS_W) begin : g_bad_addr
         $error("mwa_adapter: ADDR_W must be at least OFS_W");
      end
      if (ADDR_W > OFS_W) begin : g_hi_bits
         logic unused_hi;
         assign unused_hi = ^req_addr[ADDR_W-1:OFS_W];
      end
   endgenerate

   logic [OFS_W-1:0] in_ofs;
   wid_e             in_wid;
   plan_e            p_mode;
   logic [1:0]       p_sl, p_nl;
   logic [2:0]       p_nops;
   logic [OFS_W-1:0] p_ofs;

   assign in_ofs = req_addr[OFS_W-1:0];

   mwa_width_lut #(.OFS_W(OFS_W), .REGION_LG(REGION_LG), .WIDTH_MAP(WIDTH_MAP)) lut_i (
      .ofs (in_ofs),
      .wid (in_wid)
   );

   mwa_planner #(.OFS_W(OFS_W), .LIMIT(LIMIT)) plan_i (
      .wr        (req_write),
      .size_code (req_size),
      .ofs       (in_ofs),
      .wid       (in_wid),
      .mode      (p_mode),
      .sl        (p_sl),
      .nl        (p_nl),
      .nops      (p_nops),
      .ofs_al    (p_ofs)
   );

   st_e              st;
   plan_e            l_mode;
   logic [1:0]       l_sl, l_nl, step;
   logic [2:0]       l_nops;
   logic [OFS_W-1:0] l_ofs;
   logic             l_wr;
   logic [31:0]      l_wdata, hold, acc, nat_rdata;
   logic [4:0]       lane_sh;

   mwa_subop #(.OFS_W(OFS_W)) sub_i (
      .mode     (l_mode),
      .nl       (l_nl),
      .sl       (l_sl),
      .ofs      (l_ofs),
      .step     (step),
      .nops     (l_nops),
      .wr       (l_wr),
      .wdata    (l_wdata),
      .hold     (hold),
      .op_addr  (nat_addr),
      .op_size  (nat_size),
      .op_we    (nat_we),
      .op_wdata (nat_wdata),
      .lane_sh  (lane_sh)
   );

   assign nat_en = (st == ST_RUN);

   mwa_regfile #(.OFS_W(OFS_W), .LIMIT(LIMIT), .REGION_LG(REGION_LG), .WIDTH_MAP(WIDTH_MAP)) rf_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (nat_en),
      .we    (nat_we),
      .size  (nat_size),
      .addr  (nat_addr),
      .wdata (nat_wdata),
      .rdata (nat_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         l_mode  <= PLAN_VOID;
         l_sl    <= 2'd0;
         l_nl    <= 2'd0;
         l_nops  <= 3'd0;
         l_ofs   <= '0;
         l_wr    <= 1'b0;
         l_wdata <= 32'd0;
         step    <= 2'd0;
         hold    <= 32'd0;
         acc     <= 32'd0;
      end else begin
         case (st)
            ST_IDLE: if (req_valid) begin
               l_mode  <= p_mode;
               l_sl    <= p_sl;
               l_nl    <= p_nl;
               l_nops  <= p_nops;
               l_ofs   <= p_ofs;
               l_wr    <= req_write;
               l_wdata <= req_wdata;
               step    <= 2'd0;
               acc     <= 32'd0;
               st      <= (p_mode == PLAN_VOID) ? ST_RESP : ST_RUN;
            end
            ST_RUN: begin
               if (step == 2'd0) hold <= nat_rdata;
               if (!l_wr) begin
                  case (l_mode)
                     PLAN_DIRECT: acc <= nat_rdata;
                     PLAN_NARROW: acc <= (nat_rdata >> lane_sh) & lg_mask(l_sl);
                     PLAN_SPLIT:  acc <= (l_nl == 2'd0) ? {acc[23:0], nat_rdata[7:0]}
                                                        : {acc[15:0], nat_rdata[15:0]};
                     default: ;
                  endcase
               end
               step <= step + 2'd1;
               if ({1'b0, step} + 3'd1 == l_nops) st <= ST_RESP;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st == ST_IDLE);
   assign rsp_valid = (st == ST_RESP);
   assign rsp_rdata = acc;

   // R10
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (req_ready && !rsp_valid));

   // R10
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R2
   oor_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && ({1'b0, req_addr[OFS_W-1:0]} >= LIMIT_V)) |=> (rsp_valid && !nat_en));

   // R8
   rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nat_en && nat_we && l_mode == PLAN_NARROW) |->
         ($past(nat_en) && !$past(nat_we) && $past(nat_addr) == nat_addr));

   // R11
   wr_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && l_wr) |-> (rsp_rdata == 32'd0));

endmodule

// File: tb/mwa_adapter_tb_top.sv
module mwa_adapter_tb_top;

   localparam int LIM = 512;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write;
   logic [1:0]  req_size;
   logic [15:0] req_addr;
   logic [31:0] req_wdata;
   logic        req_ready, rsp_valid;
   logic [31:0] rsp_rdata;
   logic        nat_en, nat_we;
   logic [1:0]  nat_size;
   logic [9:0]  nat_addr;
   logic [31:0] nat_wdata;

   always #10 clk = ~clk;

   mwa_adapter dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .nat_en(nat_en), .nat_we(nat_we), .nat_size(nat_size),
      .nat_addr(nat_addr), .nat_wdata(nat_wdata)
   );

   int          total = 0;
   int          bad = 0;
   bit          finished = 0;
   logic [7:0]  mdl [LIM];
   int          op_cnt;
   logic [9:0]  op_addr [4];
   logic        op_we   [4];
   logic [1:0]  op_size [4];
   logic [31:0] op_wd   [4];

   always @(negedge clk) begin
      if (rst_n && nat_en) begin
         if (op_cnt < 4) begin
            op_addr[op_cnt] = nat_addr;
            op_we[op_cnt]   = nat_we;
            op_size[op_cnt] = nat_size;
            op_wd[op_cnt]   = nat_wdata;
         end
         op_cnt++;
      end
   end

   function automatic int region_w(int o);
      case ((o >> 6) & 3)
         0: return 1;
         1: return 2;
         2: return 4;
         default: return 0;
      endcase
   endfunction

   function automatic logic [31:0] mread(int o, int n);
      logic [31:0] v = 32'd0;
      for (int b = 0; b < n; b++) begin
         v = (v << 8) | ((region_w(o + b) == 0) ? 32'd0 : {24'd0, mdl[o + b]});
      end
      return v;
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(bit wr, int code, int addr, logic [31:0] wd, string note);
      int s, o, nw, nops, lat, esz, ea;
      bit oor, none, rdy_busy, ok, ewe;
      string tag;
      logic [31:0] rd, ex;
      s    = (code == 0) ? 1 : (code == 1) ? 2 : 4;
      o    = (addr & 'h3FF) & ~(s - 1);
      oor  = (o >= LIM);
      none = !oor && region_w(o) == 0;
      nw   = oor ? 1 : ((region_w(o) == 0) ? 1 : region_w(o));
      esz  = (nw == 1) ? 0 : (nw == 2) ? 1 : 2;
      if (oor) begin nops = 0; tag = "R2"; end
      else if (s == nw) begin nops = 1; tag = "R5"; end
      else if (s < nw) begin nops = wr ? 2 : 1; tag = wr ? "R8" : "R6"; end
      else begin nops = s / nw; tag = wr ? "R9" : "R7"; end
      if (none) tag = {tag, "/R4"};
      tag = {note, tag, $sformatf(" %s size=%0d addr=%h", wr ? "wr" : "rd", code, addr)};

      @(negedge clk);
      op_cnt    = 0;
      req_valid = 1'b1;
      req_write = wr;
      req_size  = 2'(code);
      req_addr  = 16'(addr);
      req_wdata = wd;
      lat = 0;
      do begin
         @(negedge clk);
         if (lat == 0) req_valid = 1'b0;
         lat++;
      end while (!rsp_valid && lat < 20);
      rd = rsp_rdata;
      rdy_busy = req_ready;
      @(negedge clk);
      check(lat == nops + 1 && !rdy_busy && req_ready, {"R10 timing ", tag}, 32'(lat), 32'(nops + 1));

      if (wr && !oor) begin
         for (int b = 0; b < s; b++) begin
            if (region_w(o + b) != 0) mdl[o + b] = 8'(wd >> (8 * (s - 1 - b)));
         end
      end

      ok = (op_cnt == nops);
      for (int k = 0; k < nops && k < 4; k++) begin
         ea  = (s < nw) ? (o & ~(nw - 1)) : (o + k * nw);
         ewe = wr && !(s < nw && k == 0);
         if (op_addr[k] != 10'(ea) || op_we[k] != ewe || op_size[k] != 2'(esz)) ok = 0;
         if (ok && op_we[k] && !none && op_wd[k] != mread(ea, nw)) ok = 0;
         if (op_addr[k] >= 10'(LIM)) ok = 0;
      end
      check(ok, {"R12 ops ", tag}, 32'(op_cnt), 32'(nops));

      if (wr) begin
         check(rd == 32'd0, {"R11 ", tag}, rd, 32'd0);
      end else begin
         ex = oor ? 32'd0 : mread(o, s);
         check(rd == ex, {"data ", tag}, rd, ex);
      end
   endtask

   task automatic read_sweep(string note);
      for (int c = 0; c < 3; c++) begin
         for (int o = 0; o < LIM; o += (1 << c)) access(1'b0, c, o, 32'd0, note);
      end
   endtask

   initial begin
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_write = 1'b0;
      req_size  = 2'd0;
      req_addr  = 16'd0;
      req_wdata = 32'd0;
      op_cnt    = 0;
      for (int i = 0; i < LIM; i++) mdl[i] = 8'(i) ^ 8'h5A;
      repeat (3) @(negedge clk);
      check(req_ready && !rsp_valid && !nat_en, "R10 reset state", {29'd0, req_ready, rsp_valid, nat_en}, 32'h4);
      rst_n = 1'b1;

      // R4 reset contents and width map, all sizes
      read_sweep("R4 reset ");

      // write sweeps, one size at a time, each followed by a full reread
      for (int c = 0; c < 3; c++) begin
         for (int o = 0; o < LIM; o += (1 << c)) begin
            access(1'b1, c, o, (32'(o) * 32'h0101_0107) ^ 32'hC3A5_1E00 ^ 32'(c * 77), "");
         end
         read_sweep("");
      end

      // R3 size code 3, unaligned addresses, unused upper data bits
      for (int o = 0; o < LIM; o += 20) begin
         access(1'b0, 3, o, 32'd0, "R3 ");
         access(1'b0, 2, o + 3, 32'd0, "R3 ");
         access(1'b0, 1, o + 1, 32'd0, "R3 ");
         access(1'b1, 0, o + 2, 32'hFFFF_FF00 | 32'(o), "R3 ");
         access(1'b1, 1, o + 1, 32'hABCD_0000 | 32'(o * 3), "R3 ");
      end

      // R2 out-of-range accesses then confirm the window is untouched
      for (int a = 'h200; a < 'h400; a += 'h2C) begin
         access(1'b1, a % 3, a, 32'h1234_5678, "R2 ");
         access(1'b0, a % 3, a, 32'd0, "R2 ");
      end
      read_sweep("R2 after ");

      // R1 aliasing through upper address bits
      for (int o = 0; o < LIM; o += 36) begin
         access(1'b1, 2, 'h0400 | o, 32'h0F1E_2D3C ^ 32'(o), "R1 ");
         access(1'b0, 2, 'hFC00 | o, 32'd0, "R1 ");
         access(1'b0, 0, 'h8000 | (o + 1), 32'd0, "R1 ");
      end
      read_sweep("R1 after ");

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL R10 watchdog expired actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule